// File: doc/BRIEF.md
# Register Result Status Rename Table

This block pairs an architectural register file with a per-register producer table for a dynamically scheduled execution core. Each table entry either is blank, meaning the register file holds the current value, or names the reservation station tag that will deliver the next value. When an instruction issues, two source registers are looked up in the same cycle. Each source comes back as either a ready value or the tag of the station that will produce it. The destination register is then pointed at the new instruction's station tag.

A single result broadcast bus carries a tag and a data word. The block watches this bus. A register takes the broadcast value only while its entry still names that tag. A later issue to the same register replaces the producer, so an older result can no longer overwrite the newer pending value. This removes write-after-write and write-after-read stalls. Lookups made in the same cycle as a matching broadcast see the broadcast value. A flush input clears every pending producer at once, for example after a misprediction.

Top module: `rrs_rename_table`

## Requirements
- R1: After reset, every table entry is blank and every register value is zero. A lookup of any register then returns ready with value zero.
- R2: A lookup of a register whose entry is blank returns rdy=1, the stored value, and tag 0. Tag value 0 is reserved to mean blank, so station tags are nonzero.
- R3: A lookup of a register whose entry holds a nonzero tag, with no matching broadcast in that cycle, returns rdy=0 and that tag.
- R4: An issue (iss_valid_i=1, flush_i=0) sets the destination's entry to iss_tag_i at the next clock edge. This replaces any earlier pending producer.
- R5: A broadcast writes its data only into registers whose entry equals the broadcast tag. All other registers and entries are left unchanged.
- R6: At the edge where a matching broadcast writes a register, that register's entry becomes blank.
- R7: A lookup in a cycle where the looked-up entry equals a valid nonzero broadcast tag returns rdy=1 and the broadcast data.
- R8: If an issue targets a register that a broadcast clears in the same cycle, the entry takes the new issue tag.
- R9: flush_i clears every entry to blank at the next edge. It takes priority over an issue in the same cycle.
- R10: A broadcast with tag 0 changes no register value and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all pending producers |
| iss_valid_i | input | 1 | Instruction issues this cycle |
| iss_rs1_i | input | $clog2(NREG) | First source register |
| iss_rs2_i | input | $clog2(NREG) | Second source register |
| iss_rd_i | input | $clog2(NREG) | Destination register |
| iss_tag_i | input | TW | Station tag of issuing instruction (nonzero) |
| src1_rdy_o | output | 1 | First source value is available |
| src1_val_o | output | DW | First source value |
| src1_tag_o | output | TW | First source producer tag (0 when ready) |
| src2_rdy_o | output | 1 | Second source value is available |
| src2_val_o | output | DW | Second source value |
| src2_tag_o | output | TW | Second source producer tag (0 when ready) |
| cdb_valid_i | input | 1 | Broadcast bus carries a result |
| cdb_tag_i | input | TW | Tag of the broadcasting station |
| cdb_data_i | input | DW | Broadcast result value |

## Verification
Source lookups are combinational, so their results are due in the same cycle the indices and the broadcast are presented, including the bypass. Updates from issue, broadcast and flush take effect one clock edge later. The bench drives inputs just after the falling edge and samples lookups a quarter period later. It advances its reference table only after the rising edge, using the inputs held in that cycle, so each effect is checked by a lookup in the next cycle.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int unsigned DEF_NREG = 16;
  localparam int unsigned DEF_TW   = 4;
  localparam int unsigned DEF_DW   = 32;
endpackage

// File: rtl/rrs_status_table.sv
module rrs_status_table #(
  parameter int unsigned NREG = 16,
  parameter int unsigned TW   = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_idx_i,
  input  logic [TW-1:0]            wr_tag_i,
  input  logic                     cdb_valid_i,
  input  logic [TW-1:0]            cdb_tag_i,
  output logic [NREG-1:0][TW-1:0]  status_o,
  output logic [NREG-1:0]          hit_o
);
  logic [NREG-1:0][TW-1:0] st_q;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    assign hit_o[i] = cdb_valid_i && (cdb_tag_i != '0) && (st_q[i] == cdb_tag_i);

    // issue beats a same-cycle clear; flush beats both
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    st_q[i] <= '0;
      else if (flush_i)                               st_q[i] <= '0;
      else if (wr_en_i && (wr_idx_i == AW'(i)))       st_q[i] <= wr_tag_i;
      else if (hit_o[i])                              st_q[i] <= '0;
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/rrs_value_file.sv
module rrs_value_file #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREG-1:0]          hit_i,
  input  logic [DW-1:0]            data_i,
  output logic [NREG-1:0][DW-1:0]  value_o
);
  logic [NREG-1:0][DW-1:0] v_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       v_q[i] <= '0;
      else if (hit_i[i]) v_q[i] <= data_i;
    end
  end

  assign value_o = v_q;
endmodule

// File: rtl/rrs_src_port.sv
module rrs_src_port #(
  parameter int unsigned NREG = 16,
  parameter int unsigned TW   = 4,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [AW-1:0]            idx_i,
  input  logic [NREG-1:0][TW-1:0]  status_i,
  input  logic [NREG-1:0][DW-1:0]  value_i,
  input  logic                     cdb_valid_i,
  input  logic [TW-1:0]            cdb_tag_i,
  input  logic [DW-1:0]            cdb_data_i,
  output logic                     rdy_o,
  output logic [DW-1:0]            val_o,
  output logic [TW-1:0]            tag_o
);
  logic [TW-1:0] st;
  logic          byp;

  always_comb begin
    st    = status_i[idx_i];
    byp   = cdb_valid_i && (cdb_tag_i != '0) && (st == cdb_tag_i);
    rdy_o = (st == '0) || byp;
    val_o = byp ? cdb_data_i : value_i[idx_i];
    tag_o = rdy_o ? '0 : st;
  end
endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table
  import rrs_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG,
  parameter int unsigned TW   = DEF_TW,
  parameter int unsigned DW   = DEF_DW,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          iss_valid_i,
  input  logic [AW-1:0] iss_rs1_i,
  input  logic [AW-1:0] iss_rs2_i,
  input  logic [AW-1:0] iss_rd_i,
  input  logic [TW-1:0] iss_tag_i,
  output logic          src1_rdy_o,
  output logic [DW-1:0] src1_val_o,
  output logic [TW-1:0] src1_tag_o,
  output logic          src2_rdy_o,
  output logic [DW-1:0] src2_val_o,
  output logic [TW-1:0] src2_tag_o,
  input  logic          cdb_valid_i,
  input  logic [TW-1:0] cdb_tag_i,
  input  logic [DW-1:0] cdb_data_i
);
  localparam int unsigned NSRC = 2;

  logic [NREG-1:0][TW-1:0] status_q;
  logic [NREG-1:0][DW-1:0] value_q;
  logic [NREG-1:0]         hit;

  logic [NSRC-1:0][AW-1:0] s_idx;
  logic [NSRC-1:0]         s_rdy;
  logic [NSRC-1:0][DW-1:0] s_val;
  logic [NSRC-1:0][TW-1:0] s_tag;

  rrs_status_table #(.NREG(NREG), .TW(TW)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .wr_en_i     (iss_valid_i),
    .wr_idx_i    (iss_rd_i),
    .wr_tag_i    (iss_tag_i),
    .cdb_valid_i (cdb_valid_i),
    .cdb_tag_i   (cdb_tag_i),
    .status_o    (status_q),
    .hit_o       (hit)
  );

  rrs_value_file #(.NREG(NREG), .DW(DW)) u_vals (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .data_i  (cdb_data_i),
    .value_o (value_q)
  );

  assign s_idx[0] = iss_rs1_i;
  assign s_idx[1] = iss_rs2_i;

  for (genvar p = 0; p < NSRC; p++) begin : g_src
    rrs_src_port #(.NREG(NREG), .TW(TW), .DW(DW)) u_port (
      .idx_i       (s_idx[p]),
      .status_i    (status_q),
      .value_i     (value_q),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_data_i  (cdb_data_i),
      .rdy_o       (s_rdy[p]),
      .val_o       (s_val[p]),
      .tag_o       (s_tag[p])
    );
  end

  assign src1_rdy_o = s_rdy[0];
  assign src1_val_o = s_val[0];
  assign src1_tag_o = s_tag[0];
  assign src2_rdy_o = s_rdy[1];
  assign src2_val_o = s_val[1];
  assign src2_tag_o = s_tag[1];
endmodule

// File: rtl/rrs_rename_table_chk.sv
module rrs_rename_table_chk #(
  parameter int unsigned NREG = 16,
  parameter int unsigned TW   = 4,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     iss_valid_i,
  input logic [AW-1:0]            iss_rs1_i,
  input logic [AW-1:0]            iss_rd_i,
  input logic [TW-1:0]            iss_tag_i,
  input logic                     src1_rdy_o,
  input logic [DW-1:0]            src1_val_o,
  input logic [TW-1:0]            src1_tag_o,
  input logic                     cdb_valid_i,
  input logic [TW-1:0]            cdb_tag_i,
  input logic [DW-1:0]            cdb_data_i,
  input logic [NREG-1:0][TW-1:0]  status_q,
  input logic [NREG-1:0][DW-1:0]  value_q
);
  logic cdb_live;
  assign cdb_live = cdb_valid_i && (cdb_tag_i != '0);

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdb_live && status_q[iss_rs1_i] == cdb_tag_i) |-> (src1_rdy_o && src1_val_o == cdb_data_i));

  assert_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[iss_rs1_i] != '0 && !(cdb_live && status_q[iss_rs1_i] == cdb_tag_i))
      |-> (!src1_rdy_o && src1_tag_o == status_q[iss_rs1_i]));

  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (status_q == '0));

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    assert_issue_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_i && !flush_i && iss_rd_i == AW'(i)) |=> (status_q[i] == $past(iss_tag_i)));

    assert_match_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cdb_live && status_q[i] == cdb_tag_i && !(iss_valid_i && iss_rd_i == AW'(i)))
        |=> (status_q[i] == '0 && value_q[i] == $past(cdb_data_i)));

    assert_nomatch_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cdb_live && status_q[i] == cdb_tag_i) |=> $stable(value_q[i]));
  end
endmodule

bind rrs_rename_table rrs_rename_table_chk #(.NREG(NREG), .TW(TW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .iss_valid_i (iss_valid_i),
  .iss_rs1_i   (iss_rs1_i),
  .iss_rd_i    (iss_rd_i),
  .iss_tag_i   (iss_tag_i),
  .src1_rdy_o  (src1_rdy_o),
  .src1_val_o  (src1_val_o),
  .src1_tag_o  (src1_tag_o),
  .cdb_valid_i (cdb_valid_i),
  .cdb_tag_i   (cdb_tag_i),
  .cdb_data_i  (cdb_data_i),
  .status_q    (status_q),
  .value_q     (value_q)
);

// File: tb/tb_rrs_rename_table.sv
module tb_rrs_rename_table;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int TW   = 4;
  localparam int DW   = 32;
  localparam int AW   = $clog2(NREG);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          iv = 1'b0;
  logic [AW-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic [TW-1:0] itag = '0;
  logic          r1, r2;
  logic [DW-1:0] v1, v2;
  logic [TW-1:0] t1, t2;
  logic          cv = 1'b0;
  logic [TW-1:0] ctag = '0;
  logic [DW-1:0] cdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] m_val [NREG];
  logic [TW-1:0] m_st  [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  rrs_rename_table dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .iss_valid_i(iv), .iss_rs1_i(rs1), .iss_rs2_i(rs2), .iss_rd_i(rd), .iss_tag_i(itag),
    .src1_rdy_o(r1), .src1_val_o(v1), .src1_tag_o(t1),
    .src2_rdy_o(r2), .src2_val_o(v2), .src2_tag_o(t2),
    .cdb_valid_i(cv), .cdb_tag_i(ctag), .cdb_data_i(cdata)
  );

  function automatic string cat(input logic [AW-1:0] r);
    if (cv && ctag != 0 && m_st[r] == ctag) return "R7";
    if (m_st[r] != 0) return "R3";
    return "R2";
  endfunction

  task automatic chk_src(input string req, input logic [AW-1:0] r,
                         input logic rdy, input logic [DW-1:0] v, input logic [TW-1:0] t);
    logic          e_rdy;
    logic [DW-1:0] e_v;
    logic [TW-1:0] e_t;
    string         lbl;
    lbl = (req == "") ? cat(r) : req;
    if (cv && ctag != 0 && m_st[r] == ctag) begin e_rdy = 1; e_v = cdata; e_t = 0; end
    else if (m_st[r] != 0) begin e_rdy = 0; e_v = 'x; e_t = m_st[r]; end
    else begin e_rdy = 1; e_v = m_val[r]; e_t = 0; end
    n_chk++;
    if (rdy !== e_rdy || t !== e_t || (e_rdy && v !== e_v)) begin
      n_fail++;
      $display("FAIL %s reg %0d: rdy=%0b tag=%0d val=%h expected rdy=%0b tag=%0d val=%h",
               lbl, r, rdy, t, v, e_rdy, e_t, e_v);
    end
  endtask

  // inputs already set after negedge; check, then clock, then update model
  task automatic step(input string req);
    #(CLK_PERIOD/4);
    chk_src(req, rs1, r1, v1, t1);
    chk_src(req, rs2, r2, v2, t2);
    @(posedge clk);
    for (int i = 0; i < NREG; i++)
      if (cv && ctag != 0 && m_st[i] == ctag) begin m_val[i] = cdata; m_st[i] = 0; end
    if (flush) for (int i = 0; i < NREG; i++) m_st[i] = 0;
    else if (iv) m_st[rd] = itag;
    @(negedge clk);
    iv = 0; cv = 0; flush = 0;
  endtask

  task automatic look(input int a, input int b);
    rs1 = AW'(a); rs2 = AW'(b);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin m_val[i] = 0; m_st[i] = 0; end
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2 + 1);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state seen through both lookups
    for (int i = 0; i < NREG; i++) begin look(i, NREG-1-i); step("R1"); end

    // R4: issue then replace
    iv = 1; rd = 3; itag = 5; look(0, 1); step("R4");
    look(3, 3); step("R4");
    iv = 1; rd = 3; itag = 7; look(3, 0); step("R3");
    look(3, 2); step("R4");
    // R5: stale broadcast tag ignored
    cv = 1; ctag = 5; cdata = 32'hdead_0005; look(3, 1); step("R5");
    look(3, 1); step("R5");
    // R7 bypass, then R6 clear
    cv = 1; ctag = 7; cdata = 32'haaaa_0007; look(3, 3); step("R7");
    look(3, 0); step("R6");
    // R8: new issue wins over same-cycle clear
    iv = 1; rd = 4; itag = 2; look(0, 0); step("R4");
    cv = 1; ctag = 2; cdata = 32'h1234; iv = 1; rd = 4; itag = 9; look(4, 1); step("R7");
    look(4, 4); step("R8");
    cv = 1; ctag = 9; cdata = 32'h55; look(1, 1); step("R6");
    look(4, 0); step("R6");
    // R9: flush beats issue
    iv = 1; rd = 5; itag = 3; step("");
    iv = 1; rd = 6; itag = 4; step("");
    flush = 1; iv = 1; rd = 7; itag = 8; look(5, 6); step("R3");
    look(5, 6); step("R9");
    look(7, 7); step("R9");
    // R10: tag 0 broadcast no effect
    cv = 1; ctag = 0; cdata = 32'hbad0_0000; look(4, 8); step("R10");
    look(4, 8); step("R10");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int pick;
      pick = $urandom_range(0, NREG-1);
      iv = ($urandom_range(0, 99) < 50);
      rd = AW'($urandom_range(0, NREG-1));
      itag = TW'($urandom_range(1, (1 << TW) - 1));
      cv = ($urandom_range(0, 99) < 60);
      ctag = ($urandom_range(0, 9) == 0) ? TW'($urandom_range(0, (1 << TW) - 1)) : m_st[pick];
      cdata = $urandom;
      flush = ($urandom_range(0, 99) < 2);
      if ($urandom_range(0, 3) == 0) look(pick, $urandom_range(0, NREG-1));
      else look($urandom_range(0, NREG-1), $urandom_range(0, NREG-1));
      step("");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule